// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Unit

This block is the front end of a small byte-wide processor. It reads one byte per cycle from a memory port with a combinational read path. It assembles each instruction of one, two or three bytes and hands it to the execution stage as a single-cycle strobe. The opcode byte alone sets the instruction length. An opcode with no entry in the internal table sends fetch to the trap entry, and no instruction is emitted for it.

The block owns the 16-bit program counter. It starts at the reset entry, and execution can redirect it at any time with a jump request. An interrupt request pulse is latched and is acted on only between instructions: one cycle without a memory read loads the interrupt entry address. Operand bytes follow the opcode high byte first. Instructions may start at any byte address, and the counter wraps from 0xFFFF to 0x0000.

Top module: `vlen_fetch`

## Requirements
- R1: While `rst_n` is low, `mem_addr` is 0x0000, `mem_rd` is 1 and `ins_valid` is 0. After release, the first opcode is read from 0x0000.
- R2: Instruction length by opcode: 1 byte for 0x00, 0x50–0x53 and 0x60–0x61; 2 bytes for 0x30–0x33 and 0x40–0x43; 3 bytes for 0x10–0x13 and 0x20–0x21. Every other opcode is illegal. `ins_len` reports the length as 1, 2 or 3 and is never 0 while `ins_valid` is high.
- R3: In every cycle with `mem_rd` high and no redirect, the next cycle reads `mem_addr`+1, wrapping 0xFFFF to 0x0000. `ins_valid` is high for exactly the one cycle after the instruction's last byte is read, so back-to-back 1-byte instructions produce a strobe every cycle.
- R4: While `ins_valid` is high, `ins_opcode` is the first byte and `ins_pc` is the opcode's address. `ins_imm8` is the second byte for a 2-byte instruction and 0 otherwise.
- R5: For a 3-byte instruction, `ins_abs16` is {second byte, third byte}, high byte first, at any byte alignment. It is 0 for other lengths.
- R6: Reading an illegal opcode gives no strobe, and the next cycle reads from the trap entry 0x0003.
- R7: An `irq_req` pulse is held pending until the next instruction boundary, and an instruction already in progress completes first. Taking the interrupt costs one cycle with `mem_rd` low, and the next read is from 0x0006.
- R8: A `jmp_req` high at a clock edge makes the next cycle read from `jmp_addr` with no strobe and discards any partly assembled instruction. A jump takes priority over both the trap and the interrupt, and a pending interrupt is kept through the jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Byte address being read (the program counter) |
| mem_rd | output | 1 | A byte is consumed from `mem_rdata` this cycle |
| mem_rdata | input | 8 | Byte at `mem_addr`, valid in the same cycle |
| irq_req | input | 1 | Interrupt request pulse, latched as pending |
| jmp_req | input | 1 | Load the program counter from `jmp_addr` |
| jmp_addr | input | 16 | Jump target address |
| ins_valid | output | 1 | Assembled instruction present, one cycle |
| ins_opcode | output | 8 | Opcode byte |
| ins_len | output | 2 | Instruction length in bytes (1 to 3) |
| ins_imm8 | output | 8 | Immediate byte of a 2-byte instruction |
| ins_abs16 | output | 16 | Big-endian address of a 3-byte instruction |
| ins_pc | output | 16 | Address of the opcode byte |

## Verification
A wrong sequencer state, such as a lost operand count or a stale length, shows up within one instruction. It appears as a strobe one cycle early or late, or as a fused or split instruction in `ins_len` and the operand fields. A wrong program counter update is visible on `mem_addr` in the very next cycle, because the counter drives the port directly. Redirects are therefore checked on the cycle right after the triggering edge. A lost or doubled pending interrupt shows up as a missing or extra 0x0006 fetch at the first boundary after the request.

// File: rtl/vlen_fetch_pkg.sv
package vlen_fetch_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    FS_OP = 2'd0,
    FS_B1 = 2'd1,
    FS_B2 = 2'd2
  } fstate_t;

  typedef enum logic [1:0] {
    LEN_BAD = 2'd0,
    LEN_1   = 2'd1,
    LEN_2   = 2'd2,
    LEN_3   = 2'd3
  } ilen_t;

  // Opcode length table (R2): group in the high nibble, index in the low.
  function automatic ilen_t op_len(byte_t op);
    ilen_t r;
    r = LEN_BAD;
    case (op[7:4])
      4'h0:      if (op[3:0] == 4'h0) r = LEN_1;
      4'h1:      if (op[3:0] < 4'h4)  r = LEN_3;
      4'h2:      if (op[3:0] < 4'h2)  r = LEN_3;
      4'h3, 4'h4: if (op[3:0] < 4'h4) r = LEN_2;
      4'h5:      if (op[3:0] < 4'h4)  r = LEN_1;
      4'h6:      if (op[3:0] < 4'h2)  r = LEN_1;
      default:   r = LEN_BAD;
    endcase
    return r;
  endfunction

  // Operands arrive high byte first (R5).
  function automatic word_t join_be(byte_t hi, byte_t lo);
    return {hi, lo};
  endfunction

  function automatic word_t pc_step(word_t pc);
    return pc + word_t'(1);
  endfunction
endpackage

// File: rtl/vf_opdec.sv
module vf_opdec
  import vlen_fetch_pkg::*;
(
  input  byte_t op,
  output ilen_t len,
  output logic  legal
);
  assign len   = op_len(op);
  assign legal = (len != LEN_BAD);
endmodule

// File: rtl/vf_next_pc.sv
module vf_next_pc
  import vlen_fetch_pkg::*;
#(
  parameter word_t TRAP_VEC = 16'h0003,
  parameter word_t IRQ_VEC  = 16'h0006
) (
  input  word_t pc,
  input  logic  take_jmp,
  input  word_t jmp_addr,
  input  logic  take_irq,
  input  logic  take_trap,
  output word_t pc_nxt
);
  // Priority: jump, interrupt, trap, sequential.
  always_comb begin
    if (take_jmp)       pc_nxt = jmp_addr;
    else if (take_irq)  pc_nxt = IRQ_VEC;
    else if (take_trap) pc_nxt = TRAP_VEC;
    else                pc_nxt = pc_step(pc);
  end
endmodule

// File: rtl/vf_assemble.sv
module vf_assemble
  import vlen_fetch_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cap_op,
  input  logic  cap_b1,
  input  logic  emit,
  input  logic  at_op,
  input  byte_t rdata,
  input  ilen_t cur_len,
  input  word_t pc,
  output ilen_t len_q,
  output logic  ins_valid,
  output byte_t ins_opcode,
  output ilen_t ins_len,
  output byte_t ins_imm8,
  output word_t ins_abs16,
  output word_t ins_pc
);
  byte_t op_q, b1_q;
  word_t pc0_q;
  ilen_t fin_len;

  assign fin_len = at_op ? cur_len : len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q       <= '0;
      b1_q       <= '0;
      pc0_q      <= '0;
      len_q      <= LEN_BAD;
      ins_valid  <= 1'b0;
      ins_opcode <= '0;
      ins_len    <= LEN_BAD;
      ins_imm8   <= '0;
      ins_abs16  <= '0;
      ins_pc     <= '0;
    end else begin
      ins_valid <= emit;
      if (cap_op) begin
        op_q  <= rdata;
        len_q <= cur_len;
        pc0_q <= pc;
      end
      if (cap_b1) b1_q <= rdata;
      if (emit) begin
        ins_opcode <= at_op ? rdata : op_q;
        ins_len    <= fin_len;
        ins_pc     <= at_op ? pc : pc0_q;
        ins_imm8   <= (fin_len == LEN_2) ? rdata : '0;
        ins_abs16  <= (fin_len == LEN_3) ? join_be(b1_q, rdata) : '0;
      end
    end
  end
endmodule

// File: rtl/vlen_fetch.sv
module vlen_fetch
  import vlen_fetch_pkg::*;
#(
  parameter word_t RESET_VEC = 16'h0000,
  parameter word_t TRAP_VEC  = 16'h0003,
  parameter word_t IRQ_VEC   = 16'h0006
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [WORD_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic              irq_req,
  input  logic              jmp_req,
  input  logic [WORD_W-1:0] jmp_addr,
  output logic              ins_valid,
  output logic [BYTE_W-1:0] ins_opcode,
  output logic [1:0]        ins_len,
  output logic [BYTE_W-1:0] ins_imm8,
  output logic [WORD_W-1:0] ins_abs16,
  output logic [WORD_W-1:0] ins_pc
);
  fstate_t state_q, state_d;
  word_t   pc_q, pc_d;
  logic    pend_q;
  ilen_t   cur_len, len_q, out_len;
  logic    cur_legal;

  // Named events, shared with the checker.
  logic at_boundary, take_jmp, take_irq, fetch_rd, take_trap, emit, cap_op, cap_b1;

  vf_opdec u_dec (.op(mem_rdata), .len(cur_len), .legal(cur_legal));

  assign at_boundary = (state_q == FS_OP);
  assign take_jmp    = jmp_req;
  assign take_irq    = !jmp_req && at_boundary && pend_q;
  assign fetch_rd    = !take_jmp && !take_irq;
  assign take_trap   = fetch_rd && at_boundary && !cur_legal;
  assign cap_op      = fetch_rd && at_boundary && cur_legal && (cur_len != LEN_1);
  assign cap_b1      = fetch_rd && (state_q == FS_B1) && (len_q == LEN_3);

  always_comb begin
    case (state_q)
      FS_OP:   emit = fetch_rd && cur_legal && (cur_len == LEN_1);
      FS_B1:   emit = fetch_rd && (len_q == LEN_2);
      FS_B2:   emit = fetch_rd;
      default: emit = 1'b0;
    endcase
  end

  always_comb begin
    if (!fetch_rd || take_trap || emit) state_d = FS_OP;
    else if (cap_op)                    state_d = FS_B1;
    else if (cap_b1)                    state_d = FS_B2;
    else                                state_d = state_q;
  end

  vf_next_pc #(.TRAP_VEC(TRAP_VEC), .IRQ_VEC(IRQ_VEC)) u_npc (
    .pc(pc_q), .take_jmp(take_jmp), .jmp_addr(jmp_addr),
    .take_irq(take_irq), .take_trap(take_trap), .pc_nxt(pc_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_OP;
      pc_q    <= RESET_VEC;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      pend_q  <= irq_req || (pend_q && !take_irq);
    end
  end

  vf_assemble u_asm (
    .clk(clk), .rst_n(rst_n), .cap_op(cap_op), .cap_b1(cap_b1), .emit(emit),
    .at_op(at_boundary), .rdata(mem_rdata), .cur_len(cur_len), .pc(pc_q),
    .len_q(len_q), .ins_valid(ins_valid), .ins_opcode(ins_opcode),
    .ins_len(out_len), .ins_imm8(ins_imm8), .ins_abs16(ins_abs16), .ins_pc(ins_pc)
  );

  assign ins_len  = out_len;
  assign mem_addr = pc_q;
  assign mem_rd   = fetch_rd;
endmodule

// File: rtl/vlen_fetch_chk.sv
module vlen_fetch_chk
  import vlen_fetch_pkg::*;
#(
  parameter word_t TRAP_VEC = 16'h0003,
  parameter word_t IRQ_VEC  = 16'h0006
) (
  input logic  clk,
  input logic  rst_n,
  input word_t mem_addr,
  input logic  mem_rd,
  input byte_t mem_rdata,
  input word_t jmp_addr,
  input logic  ins_valid,
  input logic [1:0] ins_len,
  input word_t ins_abs16,
  input logic  take_jmp,
  input logic  take_irq,
  input logic  take_trap
);
  assert_len_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> ins_len != 2'd0);

  assert_seq_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !take_trap) |=> mem_addr == word_t'($past(mem_addr) + word_t'(1)));

  assert_strobe_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> $past(mem_rd));

  assert_abs_low_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_len == 2'd3) |-> ins_abs16[7:0] == $past(mem_rdata));

  assert_trap_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |=> (mem_addr == TRAP_VEC) && !ins_valid);

  assert_irq_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> (mem_addr == IRQ_VEC) && !ins_valid);

  assert_jump_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_jmp |=> (mem_addr == $past(jmp_addr)) && !ins_valid);

  assert_single_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_jmp, take_irq, take_trap}));
endmodule

bind vlen_fetch vlen_fetch_chk #(.TRAP_VEC(TRAP_VEC), .IRQ_VEC(IRQ_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
  .mem_rdata(mem_rdata), .jmp_addr(jmp_addr), .ins_valid(ins_valid),
  .ins_len(ins_len), .ins_abs16(ins_abs16), .take_jmp(take_jmp),
  .take_irq(take_irq), .take_trap(take_trap)
);

// File: tb/vlen_fetch_test.sv
module vlen_fetch_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;
  // {opcode, expected length; 0 = illegal}, restated from R2
  localparam logic [9:0] VECS [NVEC] = '{
    {8'h00, 2'd1}, {8'h50, 2'd1}, {8'h53, 2'd1}, {8'h61, 2'd1},
    {8'h30, 2'd2}, {8'h33, 2'd2}, {8'h40, 2'd2}, {8'h43, 2'd2},
    {8'h10, 2'd3}, {8'h13, 2'd3}, {8'h20, 2'd3}, {8'h21, 2'd3},
    {8'h01, 2'd0}, {8'h14, 2'd0}, {8'h22, 2'd0}, {8'h34, 2'd0},
    {8'h44, 2'd0}, {8'h54, 2'd0}, {8'h62, 2'd0}, {8'hFF, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_rdata;
  logic        irq_req = 1'b0;
  logic        jmp_req = 1'b0;
  logic [15:0] jmp_addr = 16'h0000;
  logic        ins_valid;
  logic [7:0]  ins_opcode;
  logic [1:0]  ins_len;
  logic [7:0]  ins_imm8;
  logic [15:0] ins_abs16;
  logic [15:0] ins_pc;

  logic [7:0] mem [0:255];
  assign mem_rdata = mem[mem_addr[7:0]];

  vlen_fetch uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .irq_req(irq_req), .jmp_req(jmp_req),
    .jmp_addr(jmp_addr), .ins_valid(ins_valid), .ins_opcode(ins_opcode),
    .ins_len(ins_len), .ins_imm8(ins_imm8), .ins_abs16(ins_abs16), .ins_pc(ins_pc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] outs();
    return {13'd0, ins_valid, ins_opcode, ins_len, ins_pc, ins_imm8, ins_abs16};
  endfunction

  function automatic logic [63:0] want(logic [7:0] op, logic [1:0] l, logic [15:0] pc,
                                        logic [7:0] imm, logic [15:0] abs);
    return {13'd0, 1'b1, op, l, pc, imm, abs};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic jump_to(logic [15:0] a);
    jmp_req = 1'b1;
    jmp_addr = a;
    step();
    jmp_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) step();
    // R1: reset state
    chk("R1", {46'd0, mem_addr, ins_valid, mem_rd}, {46'd0, 16'h0000, 1'b0, 1'b1});
    rst_n = 1'b1;
    step();
    chk("R1", outs(), want(8'h00, 2'd1, 16'h0000, 8'h00, 16'h0000));
    step();
    chk("R3", outs(), want(8'h00, 2'd1, 16'h0001, 8'h00, 16'h0000));

    // R2/R4/R6: opcode table walk at 0x0040
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] op;
      logic [1:0] l;
      op = VECS[i][9:2];
      l  = VECS[i][1:0];
      mem[8'h40] = op;
      mem[8'h41] = 8'hA5;
      mem[8'h42] = 8'h3C;
      jump_to(16'h0040);
      if (l == 2'd0) begin
        step();
        chk("R6", {47'd0, mem_addr, ins_valid}, {47'd0, 16'h0003, 1'b0});
      end else begin
        repeat (l) step();
        chk("R2", outs(), want(op, l, 16'h0040,
                               (l == 2'd2) ? 8'hA5 : 8'h00,
                               (l == 2'd3) ? 16'hA53C : 16'h0000));
      end
    end

    // R6: trap entry then fetch from it
    mem[8'h40] = 8'hFF;
    jump_to(16'h0040);
    step();
    chk("R6", {48'd0, mem_addr}, {48'd0, 16'h0003});
    step();
    chk("R6", outs(), want(8'h00, 2'd1, 16'h0003, 8'h00, 16'h0000));

    // R7: interrupt during a 3-byte instruction
    mem[8'h80] = 8'h12; mem[8'h81] = 8'h12; mem[8'h82] = 8'h34;
    jmp_req = 1'b1; jmp_addr = 16'h0080;
    step();
    jmp_req = 1'b0; irq_req = 1'b1;
    step();
    irq_req = 1'b0;
    step();
    step();
    chk("R7", outs(), want(8'h12, 2'd3, 16'h0080, 8'h00, 16'h1234));
    chk("R7", {63'd0, mem_rd}, 64'd0);
    step();
    chk("R7", {47'd0, mem_addr, ins_valid}, {47'd0, 16'h0006, 1'b0});
    step();
    chk("R7", outs(), want(8'h00, 2'd1, 16'h0006, 8'h00, 16'h0000));

    // R8: jump discards a partly assembled instruction
    mem[8'h90] = 8'h30; mem[8'h91] = 8'h77; mem[8'hA0] = 8'h00;
    jump_to(16'h0090);
    step();
    jmp_req = 1'b1; jmp_addr = 16'h00A0;
    step();
    jmp_req = 1'b0;
    chk("R8", {47'd0, mem_addr, ins_valid}, {47'd0, 16'h00A0, 1'b0});
    step();
    chk("R8", outs(), want(8'h00, 2'd1, 16'h00A0, 8'h00, 16'h0000));

    // R8: jump beats interrupt, interrupt kept pending
    jmp_req = 1'b1; jmp_addr = 16'h00B0; irq_req = 1'b1;
    step();
    jmp_req = 1'b0; irq_req = 1'b0;
    chk("R8", {47'd0, mem_addr, mem_rd}, {47'd0, 16'h00B0, 1'b0});
    step();
    chk("R7", {48'd0, mem_addr}, {48'd0, 16'h0006});

    // R8: jump beats trap
    mem[8'hC0] = 8'hFF;
    jump_to(16'h00C0);
    jmp_req = 1'b1; jmp_addr = 16'h00D0;
    step();
    jmp_req = 1'b0;
    chk("R8", {48'd0, mem_addr}, {48'd0, 16'h00D0});

    // R3/R5: wrap at 0xFFFF with an unaligned 3-byte instruction
    mem[8'hFF] = 8'h20; mem[8'h00] = 8'hBE; mem[8'h01] = 8'hEF;
    jump_to(16'hFFFF);
    step();
    chk("R3", {48'd0, mem_addr}, {48'd0, 16'h0000});
    step();
    step();
    chk("R5", outs(), want(8'h20, 2'd3, 16'hFFFF, 8'h00, 16'hBEEF));

    finish_run();
  end
endmodule